// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler

This block owns one binary prescaler and lends it to one of two consumers, the timer/counter or the watchdog, as selected by a control register. Each cycle in which the input clock enable is high advances the prescaler. When the prescaler reaches the end of its selected period, a one-cycle tick goes to the consumer that holds the prescaler. The other consumer gets a tick for every input enable, so it runs undivided.

A 3-bit rate code selects the period. The same code gives the watchdog a period half as long as the timer's. The timer is divided by 2^(code+1), from 2 up to 256. The watchdog is divided by 2^code, from 1 up to 128.

Any write to the control register restarts the prescaler from zero. The first period after a write is therefore always full length. The full register value is presented at an output, because neighbouring logic decodes its other fields.

Top module: `prsc_shared`

## Requirements
- R1: After reset the control register reads 8'h00, and both tick outputs are low.
- R2: A write stores all eight data bits, which appear on `cfg_q` in the next cycle. Bit 3 is the assignment bit, bits 2..0 are the rate code, and bits 7, 6, 5 and 4 are stored only, with no effect on ticking.
- R3: With bit 3 = 0, rate code n gives one `tmr_tick` for every 2^(n+1) input enables. The first tick after a write comes on exactly the 2^(n+1)-th enable.
- R4: With bit 3 = 1, rate code n gives one `wdt_tick` for every 2^n input enables. Code 0 gives a tick on every enable.
- R5: The consumer that does not hold the prescaler gets a tick for every input enable: `wdt_tick` when bit 3 = 0, and `tmr_tick` when bit 3 = 1.
- R6: A write clears the prescaler count, so a partly elapsed period is discarded. The next prescaled tick comes a full period after the write.
- R7: In a cycle whose `clk_en` is low, no tick is produced and the prescaler count holds.
- R8: Each tick is a single-cycle pulse. It is high in the cycle after the input enable that produced it.
- R9: In a cycle in which a write occurs, the prescaled output does not tick. The unassigned output still follows `clk_en`, under the assignment that held before the write. The new setting governs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Input clock enable that advances the prescaler |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Current control register value |
| tmr_tick | output | 1 | Tick enable for the timer/counter |
| wdt_tick | output | 1 | Tick enable for the watchdog |

## Verification
If the prescaler count is corrupted, the position of the next prescaled tick moves. This shows at most one full period later, up to 256 enables. A wrong assignment decode shows within one enable: the undivided output stops ticking on every enable. A missed clear on write shows as a short first period, so the bench counts enables from each write to the first tick. It also compares every cycle against a model built from the requirements.

// File: rtl/prsc_pkg.sv
package prsc_pkg;
    localparam int RATE_W = 3;
    localparam int CFG_W  = 8;

    typedef struct packed {
        logic              edge_sel;
        logic              spare6;
        logic              src_sel;
        logic              spare4;
        logic              to_wdt;
        logic [RATE_W-1:0] rate;
    } cfg_t;
endpackage

// File: rtl/prsc_cfg_reg.sv
module prsc_cfg_reg
    import prsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    typedef struct packed {
        cfg_t val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.val;
endmodule

// File: rtl/prsc_divider.sv
module prsc_divider #(
    parameter int RATE_W = 3,
    localparam int CNT_W = 2 ** RATE_W,
    localparam int LOG_W = RATE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clear,
    input  logic [LOG_W-1:0] div_log2,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] mask;

    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask[g] = (LOG_W'(g) < div_log2);
    end

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (count_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
            hit      = ((st_q.cnt & mask) == mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/prsc_route.sv
module prsc_route (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic hit,
    input  logic to_wdt,
    output logic tmr_tick,
    output logic wdt_tick
);
    typedef struct packed {
        logic tmr;
        logic wdt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (to_wdt) begin
            st_d.tmr = clk_en;
            st_d.wdt = hit;
        end else begin
            st_d.tmr = hit;
            st_d.wdt = clk_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_tick = st_q.tmr;
    assign wdt_tick = st_q.wdt;
endmodule

// File: rtl/prsc_shared.sv
module prsc_shared
    import prsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             tmr_tick,
    output logic             wdt_tick
);
    localparam int LOG_W = RATE_W + 1;

    cfg_t             cfg;
    logic [LOG_W-1:0] div_log2;
    logic             hit;

    prsc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    always_comb begin
        if (cfg.to_wdt) begin
            div_log2 = {1'b0, cfg.rate};
        end else begin
            div_log2 = {1'b0, cfg.rate} + 1'b1;
        end
    end

    prsc_divider #(.RATE_W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (clk_en),
        .clear    (cfg_we),
        .div_log2 (div_log2),
        .hit      (hit)
    );

    prsc_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .hit      (hit),
        .to_wdt   (cfg.to_wdt),
        .tmr_tick (tmr_tick),
        .wdt_tick (wdt_tick)
    );

    assign cfg_q = cfg;
endmodule

// File: rtl/prsc_shared_chk.sv
module prsc_shared_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_q,
    input logic       tmr_tick,
    input logic       wdt_tick
);
    // R2
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> cfg_q == $past(cfg_wdata));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clk_en) |-> (!tmr_tick && !wdt_tick));

    // R5
    wdt_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_en) && !$past(cfg_q[3])) |-> wdt_tick);

    // R5
    tmr_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_en) && $past(cfg_q[3])) |-> tmr_tick);

    // R4
    wdt_code0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_en) && !$past(cfg_we) && $past(cfg_q[3]) && $past(cfg_q[2:0]) == 3'd0) |-> wdt_tick);

    // R9
    wr_tmr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && !$past(cfg_q[3])) |-> !tmr_tick);

    // R9
    wr_wdt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && $past(cfg_q[3])) |-> !wdt_tick);
endmodule

bind prsc_shared prsc_shared_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .tmr_tick  (tmr_tick),
    .wdt_tick  (wdt_tick)
);

// File: tb/prsc_shared_tb.sv
module prsc_shared_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_q;
    logic       tmr_tick, wdt_tick;

    int vectors = 0;
    int fails = 0;

    logic [7:0] m_cnt = '0;
    logic [7:0] m_cfg = '0;

    always #5 clk = ~clk;

    prsc_shared u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .tmr_tick(tmr_tick), .wdt_tick(wdt_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // One cycle with a model comparison; the model follows R3 R4 R5 R7 R8 R9.
    task automatic step(input logic en, input logic we, input logic [7:0] wd);
        logic       to_w;
        int         lg;
        logic [7:0] mask;
        logic       hit, exp_t, exp_w;
        to_w  = m_cfg[3];
        lg    = to_w ? int'(m_cfg[2:0]) : int'(m_cfg[2:0]) + 1;
        mask  = 8'((1 << lg) - 1);
        hit   = en && !we && ((m_cnt & mask) == mask);
        exp_t = to_w ? en : hit;
        exp_w = to_w ? hit : en;
        if (we) m_cnt = '0;
        else if (en) m_cnt = m_cnt + 8'd1;
        if (we) m_cfg = wd;
        @(negedge clk);
        clk_en = en; cfg_we = we; cfg_wdata = wd;
        @(posedge clk);
        #1;
        chk("R8 model tmr_tick", int'(tmr_tick), int'(exp_t));
        chk("R8 model wdt_tick", int'(wdt_tick), int'(exp_w));
        chk("R2 model cfg_q", int'(cfg_q), int'(m_cfg));
    endtask

    task automatic t_reset();
        chk("R1 cfg_q", int'(cfg_q), 0);
        chk("R1 tmr_tick", int'(tmr_tick), 0);
        chk("R1 wdt_tick", int'(wdt_tick), 0);
    endtask

    task automatic t_timer_rates();
        for (int n = 0; n < 8; n++) begin
            int tt = 0, wt = 0, first = 0;
            step(1'b0, 1'b1, 8'(n));
            for (int i = 1; i <= 256; i++) begin
                step(1'b1, 1'b0, 8'h00);
                if (tmr_tick) begin
                    tt++;
                    if (first == 0) first = i;
                end
                if (wdt_tick) wt++;
            end
            chk("R3 timer ticks per 256", tt, 256 >> (n + 1));
            chk("R3 first timer tick", first, 1 << (n + 1));
            chk("R5 wdt undivided", wt, 256);
        end
    endtask

    task automatic t_wdt_rates();
        for (int n = 0; n < 8; n++) begin
            int tt = 0, wt = 0;
            step(1'b0, 1'b1, 8'h08 | 8'(n));
            for (int i = 1; i <= 128; i++) begin
                step(1'b1, 1'b0, 8'h00);
                if (tmr_tick) tt++;
                if (wdt_tick) wt++;
            end
            chk("R4 wdt ticks per 128", wt, 128 >> n);
            chk("R5 timer undivided", tt, 128);
        end
    endtask

    task automatic t_gaps();
        int tt = 0;
        step(1'b0, 1'b1, 8'h01);
        for (int i = 0; i < 48; i++) begin
            step(1'(i % 3 != 0), 1'b0, 8'h00);
            if (tmr_tick) tt++;
        end
        chk("R7 ticks over 32 enables at ratio 4", tt, 8);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, 8'h00);
            chk("R7 idle tmr_tick", int'(tmr_tick), 0);
            chk("R7 idle wdt_tick", int'(wdt_tick), 0);
        end
    endtask

    task automatic t_restart();
        int first = 0;
        step(1'b0, 1'b1, 8'h02);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b1, 8'h02);
        for (int i = 1; i <= 8; i++) begin
            step(1'b1, 1'b0, 8'h00);
            if (tmr_tick && first == 0) first = i;
        end
        chk("R6 full period after rewrite", first, 8);
    endtask

    task automatic t_write_en();
        step(1'b0, 1'b1, 8'h00);
        step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'h08);
        chk("R9 timer silent in write cycle", int'(tmr_tick), 0);
        chk("R9 wdt follows old assignment", int'(wdt_tick), 1);
        step(1'b1, 1'b0, 8'h00);
        chk("R9 new setting wdt tick", int'(wdt_tick), 1);
        chk("R9 new setting tmr bypass", int'(tmr_tick), 1);
        step(1'b1, 1'b1, 8'h00);
        chk("R9 wdt silent in write cycle", int'(wdt_tick), 0);
        chk("R9 tmr follows old assignment", int'(tmr_tick), 1);
    endtask

    task automatic t_upper_bits();
        int tt = 0;
        step(1'b0, 1'b1, 8'hB5);
        chk("R2 upper bits stored", int'(cfg_q), 8'hB5);
        for (int i = 0; i < 128; i++) begin
            step(1'b1, 1'b0, 8'h00);
            if (tmr_tick) tt++;
        end
        chk("R2 upper bits no effect", tt, 2);
        step(1'b0, 1'b1, 8'h7D);
        chk("R2 write 7D stored", int'(cfg_q), 8'h7D);
    endtask

    task automatic t_pulse();
        logic prev = 1'b0;
        step(1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, 8'h00);
            if (prev && tmr_tick) chk("R8 single-cycle pulse", 1, 0);
            prev = tmr_tick;
        end
        chk("R8 last pulse level", int'(prev), 1);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_timer_rates();
        t_wdt_rates();
        t_gaps();
        t_restart();
        t_write_en();
        t_upper_bits();
        t_pulse();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule